// File: doc/BRIEF.md
# One-Shot Multi-Channel Conversion Sequencer

This block is the digital side of a six-input analog-to-digital converter working in one-shot scan mode. Software sets a channel mask, picks what starts a scan, and can enable an interrupt, all in a single control word. A scan starts when software writes the start bit or when a selected external trigger rises. The block then asks the analog core for one conversion per selected channel, lowest index first, and files each result in that channel's own data register. When the last result is stored, the start bit drops and a sticky completion flag rises. The interrupt line is that flag gated by the enable.

A mask with one bit set gives a single-channel scan. A mask with several bits set converts each selected channel once and then stops. Clearing the start bit while a conversion is outstanding abandons the scan at once. The abandoned conversion leaves no result behind and does not set the flag. Registers are reached through a plain synchronous port, and read data appears one cycle after the address.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control word reads 0, `irq` is 0 and `conv_start` is 0.
- R2: With exactly one mask bit set, a scan makes one conversion on that channel and stores the result in that channel's data register. The start bit (bit 6) reads 1 while the scan runs.
- R3: With several mask bits set, each selected channel is converted exactly once, in ascending index order, and its result lands in its own data register.
- R4: Only one conversion is outstanding at a time. The request for the next channel goes out in the cycle right after `conv_done` is seen.
- R5: The completion flag (bit 7) becomes 1 on the same read in which the start bit first reads 0. The flag holds until software writes bit 7 as 0. `irq` equals the flag ANDed with the interrupt enable (bit 8).
- R6: Writing the control word with bit 6 at 0 during a scan stops it immediately. No further conversions are requested, the interrupted channel's data register keeps its old value, and the flag stays 0.
- R7: A start with an all-zero mask requests no conversion. The start bit reads 1 for exactly one cycle, then returns to 0, and the flag is not set.
- R8: Trigger select (bits 10:9): 00 means software start only, and 01, 10 and 11 select `ext_trig[0]`, `[1]` and `[2]`. A trigger starts a scan only on a rising edge while idle. A level held high and an edge during a scan start nothing.
- R9: Writing bit 6 as 1 again after a scan finishes starts a new scan with the stored mask.
- R10: Address 0 is the control word: mask in bits 5:0, start 6, flag 7, enable 8, trigger select 10:9, other bits 0. Address 1+n is channel n's result. Unmapped addresses read 0. `reg_rdata` shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr_en | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the address of the previous cycle |
| ext_trig | input | 3 | External start triggers |
| conv_start | output | 1 | One-cycle request to the analog core |
| conv_chan | output | 3 | Channel index for the current request |
| conv_done | input | 1 | One-cycle completion from the analog core |
| conv_result | input | 16 | Conversion result, valid with `conv_done` |
| irq | output | 1 | Completion interrupt, level |

## Verification
A small analog-core model answers each request after a fixed delay with a value unique to that conversion. A scoreboard compares the order of requests with the channel list the driver expects. The scans use one channel, a sparse four-channel mask, a full mask that is aborted after its second request, and an empty mask. Between them, these separate single from multi-channel sequencing, a wrong ordering or skipped channel, and a stale write after an abort. Trigger tests check that a wrong input, a held level, an edge during a scan and the software-only code each start no scan. Only the matching rising edge starts one.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // waiting for a start
    ST_EMPTY = 2'd1,  // start with empty mask, drop busy next cycle
    ST_WAIT  = 2'd2,  // one conversion outstanding
    ST_FIN   = 2'd3   // last result being committed
  } scan_state_e;

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int TRIG_N = 3,
  parameter int SEL_W  = $clog2(TRIG_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TRIG_N-1:0] ext_trig,
  input  logic [SEL_W-1:0]  sel,
  output logic              trig_rise
);

  logic [TRIG_N-1:0] prev_q;
  logic [TRIG_N:0]   by_code;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= ext_trig;
  end

  // code 0 never fires; code k+1 follows input k
  assign by_code[0] = 1'b0;
  for (genvar g = 0; g < TRIG_N; g++) begin : g_edge
    assign by_code[g+1] = ext_trig[g] & ~prev_q[g];
  end

  always_comb begin
    trig_rise = 1'b0;
    if (int'(sel) <= TRIG_N) trig_rise = by_code[sel];
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_CH = 6,
  parameter int RES_W  = 16,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_idx,
  input  logic [RES_W-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_idx,
  output logic [RES_W-1:0] rd_data
);

  logic [RES_W-1:0] mem [NUM_CH];

  // single write port, registered read: maps to distributed or block RAM
  always_ff @(posedge clk) begin
    if (wr_en && int'(wr_idx) < NUM_CH) mem[wr_idx] <= wr_data;
    if (int'(rd_idx) < NUM_CH) rd_data <= mem[rd_idx];
    else                       rd_data <= '0;
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int RES_W  = 16,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_req,
  input  logic              abort_req,
  input  logic [NUM_CH-1:0] mask,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              busy,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic              wr_en,
  output logic [CH_W-1:0]   wr_idx,
  output logic [RES_W-1:0]  wr_data,
  output logic              scan_done
);

  scan_state_e       state_q;
  logic [NUM_CH-1:0] pend_q;
  logic [CH_W-1:0]   cur_q;
  logic              start_q, wr_en_q, done_q;
  logic [CH_W-1:0]   wr_idx_q;
  logic [RES_W-1:0]  wr_data_q;

  function automatic logic [CH_W-1:0] first_set(input logic [NUM_CH-1:0] m);
    first_set = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) first_set = CH_W'(i);
    end
  endfunction

  function automatic logic [NUM_CH-1:0] bit_of(input logic [CH_W-1:0] idx);
    bit_of = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(idx) == i) bit_of[i] = 1'b1;
    end
  endfunction

  logic [CH_W-1:0] pick_new, pick_next;
  assign pick_new  = first_set(mask);
  assign pick_next = first_set(pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pend_q    <= '0;
      cur_q     <= '0;
      start_q   <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
      done_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      wr_en_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go_req) begin
            if (|mask) begin
              cur_q   <= pick_new;
              pend_q  <= mask & ~bit_of(pick_new);
              start_q <= 1'b1;
              state_q <= ST_WAIT;
            end else begin
              state_q <= ST_EMPTY;
            end
          end
        end
        ST_EMPTY: state_q <= ST_IDLE;
        ST_WAIT: begin
          if (abort_req) begin
            pend_q  <= '0;
            state_q <= ST_IDLE;
          end else if (conv_done) begin
            wr_en_q   <= 1'b1;
            wr_idx_q  <= cur_q;
            wr_data_q <= conv_result;
            if (|pend_q) begin
              cur_q   <= pick_next;
              pend_q  <= pend_q & ~bit_of(pick_next);
              start_q <= 1'b1;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_FIN;
            end
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign conv_start = start_q;
  assign conv_chan  = cur_q;
  assign wr_en      = wr_en_q;
  assign wr_idx     = wr_idx_q;
  assign wr_data    = wr_data_q;
  assign scan_done  = done_q;

  // R4: a request is a single-cycle pulse, never back to back
  a_r4_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R4: a request follows either an accepted start or a completion
  a_r4_start_cause: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ($past(go_req) || $past(conv_done)));

  // R3: within a scan, channels climb strictly
  a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
    (conv_start && $past(state_q == ST_WAIT)) |-> (conv_chan > $past(conv_chan)));

  // R6: abort during a conversion returns to idle with no result write
  a_r6_abort_idle: assert property (@(posedge clk) disable iff (rst)
    (abort_req && state_q == ST_WAIT) |=> (state_q == ST_IDLE && !wr_en && !scan_done));

  // R7: empty-mask start lasts a single cycle and requests nothing
  a_r7_empty_short: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EMPTY) |=> (!busy && !conv_start));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NUM_CH = 6,
  parameter int RES_W  = 16,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 3,
  parameter int TRIG_N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [TRIG_N-1:0] ext_trig,
  output logic              conv_start,
  output logic [$clog2(NUM_CH)-1:0] conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              irq
);

  localparam int CH_W      = $clog2(NUM_CH);
  localparam int SEL_W     = $clog2(TRIG_N + 1);
  localparam int START_B   = NUM_CH;
  localparam int FLAG_B    = NUM_CH + 1;
  localparam int IE_B      = NUM_CH + 2;
  localparam int TS_LO     = NUM_CH + 3;
  localparam int USED_W    = NUM_CH + 3 + SEL_W;
  localparam int DATA_BASE = 1;

  logic [NUM_CH-1:0] mask_q;
  logic              ie_q, flag_q, irq_q;
  logic [SEL_W-1:0]  tsel_q;
  logic              flag_d, ie_d;

  logic ctrl_wr, busy, trig_rise, go_req, abort_req;
  logic [NUM_CH-1:0] go_mask;
  logic              wr_en, scan_done;
  logic [CH_W-1:0]   wr_idx;
  logic [RES_W-1:0]  wr_data;

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[REG_W-1:USED_W];

  assign ctrl_wr   = reg_wr_en && (reg_addr == ADDR_W'(0));
  assign go_req    = (ctrl_wr && reg_wdata[START_B]) || trig_rise;
  assign abort_req = ctrl_wr && !reg_wdata[START_B] && busy;
  assign go_mask   = ctrl_wr ? reg_wdata[NUM_CH-1:0] : mask_q;

  adc_trig_sel #(.TRIG_N(TRIG_N), .SEL_W(SEL_W)) u_trig (
    .clk(clk), .rst(rst), .ext_trig(ext_trig), .sel(tsel_q), .trig_rise(trig_rise)
  );

  adc_scan_ctrl #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst(rst), .go_req(go_req), .abort_req(abort_req), .mask(go_mask),
    .conv_done(conv_done), .conv_result(conv_result), .busy(busy),
    .conv_start(conv_start), .conv_chan(conv_chan), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .scan_done(scan_done)
  );

  // control fields and sticky flag
  always_comb begin
    ie_d   = ctrl_wr ? reg_wdata[IE_B] : ie_q;
    flag_d = flag_q;
    if (scan_done)                        flag_d = 1'b1;
    else if (ctrl_wr && !reg_wdata[FLAG_B]) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ie_q   <= 1'b0;
      tsel_q <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mask_q <= reg_wdata[NUM_CH-1:0];
        tsel_q <= reg_wdata[TS_LO +: SEL_W];
      end
      ie_q   <= ie_d;
      flag_q <= flag_d;
      irq_q  <= flag_d & ie_d;
    end
  end

  assign irq = irq_q;

  // read path
  logic [CH_W-1:0]   rd_idx;
  logic [RES_W-1:0]  bank_rd;
  logic              data_hit;
  logic              sel_ctrl_q, sel_data_q;
  logic [REG_W-1:0]  ctrl_rd_q;

  assign data_hit = (int'(reg_addr) >= DATA_BASE) && (int'(reg_addr) < DATA_BASE + NUM_CH);
  assign rd_idx   = CH_W'(reg_addr - ADDR_W'(DATA_BASE));

  adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(bank_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ctrl_q <= 1'b0;
      sel_data_q <= 1'b0;
      ctrl_rd_q  <= '0;
    end else begin
      sel_ctrl_q <= (reg_addr == ADDR_W'(0));
      sel_data_q <= data_hit;
      ctrl_rd_q  <= REG_W'({tsel_q, ie_q, flag_q, busy, mask_q});
    end
  end

  assign reg_rdata = sel_ctrl_q ? ctrl_rd_q :
                     sel_data_q ? REG_W'(bank_rd) : '0;

  // R5: flag rises only as a scan ends
  a_r5_flag_on_finish: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $fell(busy));

  // R5: interrupt never without the flag
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag_q);

  // R2: requests only go out during a scan
  a_r2_start_while_busy: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int NUM_CH = 6;
  localparam int LAT    = 5;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  reg_addr;
  logic        reg_wr_en;
  logic [15:0] reg_wdata, reg_rdata;
  logic [2:0]  ext_trig;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic        conv_done;
  logic [15:0] conv_result;
  logic        irq;

  always #2 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig(ext_trig),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_result(conv_result), .irq(irq)
  );

  int n_tests = 0, n_fail = 0;
  int exp_q[$];
  int starts = 0, follow_cnt = 0, cnt = 0, seq = 0, cur = 0;
  logic prev_done;
  logic [15:0] model_data [NUM_CH];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] mk(input logic [5:0] m, input logic st,
      input logic fl, input logic ie, input logic [1:0] ts);
    return {5'b0, ts, ie, fl, st, m};
  endfunction

  // analog core model and scoreboard monitor
  initial begin
    conv_done = 1'b0;
    conv_result = '0;
    prev_done = 1'b0;
    for (int i = 0; i < NUM_CH; i++) model_data[i] = '0;
    forever begin
      @(negedge clk);
      prev_done = conv_done;
      conv_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          seq++;
          conv_result = 16'(256 * (cur + 1) + seq);
          model_data[cur] = conv_result;
          conv_done = 1'b1;
        end
      end
      if (!rst && conv_start) begin
        starts++;
        if (prev_done) follow_cnt++;
        if (cnt != 0) check(1'b0, "R4", "request while busy", cnt, 0);
        cur = int'(conv_chan);
        cnt = LAT;
        if (exp_q.size() == 0) check(1'b0, "R3", "unexpected request", cur, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cur == e, "R3", "channel order", cur, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_idle(output logic [15:0] v);
    for (int i = 0; i < 300; i++) begin
      rd(3'd0, v);
      if (!v[6]) return;
    end
    check(1'b0, "R2", "scan never finished", 1, 0);
  endtask

  task automatic push_mask(input logic [5:0] m);
    for (int i = 0; i < NUM_CH; i++) if (m[i]) exp_q.push_back(i);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, old;
    int s0, f0;
    rst = 1'b1; reg_addr = '0; reg_wr_en = 1'b0; reg_wdata = '0; ext_trig = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, v);
    check(v == 16'h0, "R1", "control after reset", v, 0);
    check(irq == 1'b0 && conv_start == 1'b0, "R1", "irq/start after reset", {irq, conv_start}, 0);

    // R2 single channel 3 with interrupt enabled
    push_mask(6'h08);
    wr(3'd0, mk(6'h08, 1, 0, 1, 0));
    rd(3'd0, v);
    check(v[6] == 1'b1, "R2", "start bit while busy", v[6], 1);
    wait_idle(v);
    check(v[7] == 1'b1, "R5", "flag with start clear", v[7], 1);
    @(negedge clk);
    check(irq == 1'b1, "R5", "irq with enable", irq, 1);
    rd(3'd4, v);
    check(v == model_data[3], "R2", "channel 3 data", v, model_data[3]);
    check(exp_q.size() == 0, "R2", "pending expected", exp_q.size(), 0);

    // R5 sticky flag and clear
    repeat (5) @(negedge clk);
    rd(3'd0, v);
    check(v[7] == 1'b1, "R5", "flag sticky", v[7], 1);
    wr(3'd0, mk(6'h08, 0, 0, 1, 0));
    rd(3'd0, v);
    check(v[7] == 1'b0 && irq == 1'b0, "R5", "flag clear", {v[7], irq}, 0);

    // R3 multi-channel sparse mask, enable off
    push_mask(6'h2D);
    f0 = follow_cnt;
    wr(3'd0, mk(6'h2D, 1, 0, 0, 0));
    wait_idle(v);
    check(v[7] == 1'b1, "R5", "flag after multi", v[7], 1);
    check(irq == 1'b0, "R5", "irq gated by enable", irq, 0);
    check(follow_cnt - f0 == 3, "R4", "next request right after done", follow_cnt - f0, 3);
    for (int c = 0; c < NUM_CH; c++) begin
      if (c == 0 || c == 2 || c == 3 || c == 5) begin
        rd(3'(c + 1), v);
        check(v == model_data[c], "R3", "multi data", v, model_data[c]);
      end
    end
    check(exp_q.size() == 0, "R3", "all channels converted", exp_q.size(), 0);

    // R9 restart with same mask
    rd(3'd6, old);
    push_mask(6'h2D);
    wr(3'd0, mk(6'h2D, 1, 0, 0, 0));
    wait_idle(v);
    rd(3'd6, v);
    check(v == model_data[5] && v != old, "R9", "restart updates data", v, model_data[5]);

    // R6 abort after second request
    rd(3'd2, old);
    push_mask(6'h3F);
    s0 = starts;
    wr(3'd0, mk(6'h3F, 1, 0, 0, 0));
    for (int i = 0; i < 100 && starts < s0 + 2; i++) @(negedge clk);
    wr(3'd0, mk(6'h3F, 0, 0, 0, 0));
    rd(3'd0, v);
    check(v[6] == 1'b0, "R6", "start clear after abort", v[6], 0);
    repeat (20) @(negedge clk);
    check(starts == s0 + 2, "R6", "no request after abort", starts - s0, 2);
    rd(3'd0, v);
    check(v[7] == 1'b0, "R6", "no flag on abort", v[7], 0);
    rd(3'd2, v);
    check(v == old, "R6", "interrupted channel unchanged", v, old);
    exp_q.delete();

    // R7 empty mask: busy one cycle only
    s0 = starts;
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = mk(6'h00, 1, 0, 0, 0); reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    @(negedge clk);
    check(reg_rdata[6] == 1'b1, "R7", "start bit one cycle", reg_rdata[6], 1);
    @(negedge clk);
    check(reg_rdata[6] == 1'b0 && reg_rdata[7] == 1'b0, "R7", "start clear, no flag",
          reg_rdata[7:6], 0);
    repeat (10) @(negedge clk);
    check(starts == s0, "R7", "no request on empty mask", starts - s0, 0);

    // R8 trigger select 01: wrong input ignored, rising edge starts, level does not retrigger
    wr(3'd0, mk(6'h02, 0, 0, 0, 2'b01));
    s0 = starts;
    @(negedge clk); ext_trig = 3'b010;
    @(negedge clk); ext_trig = 3'b000;
    repeat (10) @(negedge clk);
    check(starts == s0, "R8", "unselected trigger", starts - s0, 0);
    push_mask(6'h02);
    @(negedge clk); ext_trig = 3'b001;
    wait_idle(v);
    check(v[7] == 1'b1, "R8", "trigger scan completes", v[7], 1);
    rd(3'd2, v);
    check(v == model_data[1], "R8", "triggered data", v, model_data[1]);
    repeat (20) @(negedge clk);
    check(starts == s0 + 1, "R8", "held level no retrigger", starts - s0, 1);
    ext_trig = 3'b000;

    // R8 select 11, edge during scan ignored
    wr(3'd0, mk(6'h02, 0, 0, 0, 2'b11));
    push_mask(6'h02);
    s0 = starts;
    @(negedge clk); ext_trig = 3'b100;
    repeat (2) @(negedge clk); ext_trig = 3'b000;
    @(negedge clk); ext_trig = 3'b100;
    wait_idle(v);
    repeat (10) @(negedge clk);
    check(starts == s0 + 1, "R8", "edge while busy ignored", starts - s0, 1);
    ext_trig = 3'b000;

    // R8 select 00 software only
    wr(3'd0, mk(6'h02, 0, 0, 0, 2'b00));
    s0 = starts;
    @(negedge clk); ext_trig = 3'b111;
    @(negedge clk); ext_trig = 3'b000;
    repeat (10) @(negedge clk);
    check(starts == s0, "R8", "software-only code", starts - s0, 0);

    // R10 field readback and unmapped address
    wr(3'd0, mk(6'h15, 0, 0, 1, 2'b10));
    rd(3'd0, v);
    check(v == mk(6'h15, 0, 0, 1, 2'b10), "R10", "control readback", v, mk(6'h15, 0, 0, 1, 2'b10));
    rd(3'd7, v);
    check(v == 16'h0, "R10", "unmapped address", v, 0);

    finish_run();
  end

endmodule